// File: doc/BRIEF.md
# Event Timestamp Timer Pair

This block timestamps an asynchronous pulse-per-second style event against a free-running reference time. Two counters of `CNT_W` bits (16 by default) advance on a common tick, produced once every `PRESCALE` clocks (4 by default). The reference counter runs freely and wraps. The age counter stays at zero until the first rising edge of the event. Each later rising edge clears it, and it then counts the ticks that have passed since that edge.

A polling host pulses `snap`. That pulse latches the synchronized event level, the reference count and the age count in one cycle, and the host reads them back through a small register-read port. When a snapshot finds the level high and the previous snapshot found it low, the capture unit computes the reference count minus the age count, modulo 2^CNT_W. This value is the reference time at which the edge happened, even when the host polled late. The value appears on `stamp` with a one-cycle `stamp_vld` strobe. A selectable-polarity echo output mirrors the synchronized event level for visual indication.

Top module: `edge_stamp_timer`

## Requirements
- R1: After reset the reference count is zero, and it advances by exactly one on every `PRESCALE`-th clock (default 4) and holds in every other cycle.
- R2: The reference count wraps from all ones to zero.
- R3: The age count is zero from reset until the first rising edge. In the cycle where the synchronized level turns high, it is cleared to zero, and after that it advances on each tick.
- R4: The age count saturates at all ones and does not wrap, until the next rising edge clears it.
- R5: A `snap` pulse latches the synchronized level, the reference count and the age count in the same clock. From the next cycle `rd_data` returns them for `rd_sel` 0 (level in bit 0, other bits zero), 1 (reference) and 2 (age). `rd_sel` 3 returns zero.
- R6: When a snapshot samples the level high and the previous snapshot (or reset) had it low, `stamp_vld` is high for exactly the next cycle. In that cycle `stamp` equals the sampled reference minus the sampled age, modulo 2^CNT_W.
- R7: A snapshot that samples the level low, or high again without an intervening low snapshot, raises no `stamp_vld` and leaves `stamp` unchanged.
- R8: `echo_out` equals the synchronized level XOR `echo_inv` while `echo_en` is 1. It follows both transitions of the event and is 0 while `echo_en` is 0.
- R9: The event passes a two-flop synchronizer, so a change on `evt_in` is seen on the level two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Asynchronous event input |
| snap | input | 1 | Snapshot strobe, one cycle |
| rd_sel | input | 2 | Read select: 0 level, 1 reference, 2 age, 3 zero |
| rd_data | output | CNT_W | Selected snapshot value |
| stamp | output | CNT_W | Reconstructed edge time |
| stamp_vld | output | 1 | One-cycle strobe for a new `stamp` |
| echo_en | input | 1 | Echo output enable |
| echo_inv | input | 1 | Echo polarity: 1 inverts |
| echo_out | output | 1 | Echo of the synchronized event |

## Verification
The clear of the age counter can fall in the same cycle as a tick, and a snapshot can be taken in the first cycle after the edge becomes visible. The bench provokes both. It raises the event and snapshots as soon as the level is high, at tick phases that differ from pass to pass. It expects an age of zero and a stamp equal to the sampled reference. A second overlap is a reference wrap that lands between two snapshots. It is judged on a narrow instance by checking that every pair of consecutive readings differs by one modulo 2^CNT_W.

// File: rtl/est_pkg.sv
package est_pkg;
   typedef enum logic [1:0] {
      SEL_LEVEL = 2'd0,
      SEL_REF   = 2'd1,
      SEL_AGE   = 2'd2,
      SEL_ZERO  = 2'd3
   } rd_sel_e;
endpackage

// File: rtl/est_tick_gen.sv
module est_tick_gen #(
   parameter int PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
         logic [PW-1:0] phase_q;
         assign tick = (phase_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    phase_q <= '0;
            else if (tick) phase_q <= '0;
            else           phase_q <= phase_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/est_sync_edge.sv
module est_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end
   assign level = chain_q[STAGES-1];
   // high in the cycle before level turns on
   assign rise  = chain_q[STAGES-2] & ~chain_q[STAGES-1];
endmodule

// File: rtl/est_counters.sv
module est_counters #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         rise,
   output logic [W-1:0] ref_cnt,
   output logic [W-1:0] age_cnt
);
   localparam logic [W-1:0] ALL_ONES = '1;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ref_cnt <= '0;
      else if (tick) ref_cnt <= ref_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_cnt <= '0;
         armed_q <= 1'b0;
      end else if (rise) begin
         age_cnt <= '0;
         armed_q <= 1'b1;
      end else if (tick && armed_q && age_cnt != ALL_ONES) begin
         age_cnt <= age_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/est_capture.sv
module est_capture
   import est_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         snap,
   input  logic         level,
   input  logic [W-1:0] ref_cnt,
   input  logic [W-1:0] age_cnt,
   input  logic [1:0]   rd_sel,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] stamp,
   output logic         stamp_vld
);
   logic         lvl_q;
   logic [W-1:0] ref_q;
   logic [W-1:0] age_q;
   logic         prev_q;
   logic         fresh;

   assign fresh = snap & level & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q     <= 1'b0;
         ref_q     <= '0;
         age_q     <= '0;
         prev_q    <= 1'b0;
         stamp     <= '0;
         stamp_vld <= 1'b0;
      end else begin
         stamp_vld <= fresh;
         if (fresh) stamp <= ref_cnt - age_cnt;
         if (snap) begin
            lvl_q  <= level;
            ref_q  <= ref_cnt;
            age_q  <= age_cnt;
            prev_q <= level;
         end
      end
   end

   always_comb begin
      case (rd_sel_e'(rd_sel))
         SEL_LEVEL: rd_data = {{(W-1){1'b0}}, lvl_q};
         SEL_REF:   rd_data = ref_q;
         SEL_AGE:   rd_data = age_q;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer #(
   parameter int CNT_W       = 16,
   parameter int PRESCALE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_in,
   input  logic             snap,
   input  logic [1:0]       rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic [CNT_W-1:0] stamp,
   output logic             stamp_vld,
   input  logic             echo_en,
   input  logic             echo_inv,
   output logic             echo_out
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             tick;
   logic             lvl;
   logic             rise;
   logic [CNT_W-1:0] ref_cnt;
   logic [CNT_W-1:0] age_cnt;

   est_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   est_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(evt_in), .level(lvl), .rise(rise));

   est_counters #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rise(rise),
      .ref_cnt(ref_cnt), .age_cnt(age_cnt));

   est_capture #(.W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .snap(snap), .level(lvl),
      .ref_cnt(ref_cnt), .age_cnt(age_cnt), .rd_sel(rd_sel),
      .rd_data(rd_data), .stamp(stamp), .stamp_vld(stamp_vld));

   assign echo_out = echo_en & (lvl ^ echo_inv);
endmodule

// File: rtl/edge_stamp_timer_chk.sv
module edge_stamp_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         rise,
   input logic         lvl,
   input logic         snap,
   input logic [W-1:0] ref_cnt,
   input logic [W-1:0] age_cnt,
   input logic [W-1:0] stamp,
   input logic         stamp_vld,
   input logic         echo_en,
   input logic         echo_out
);
   localparam logic [W-1:0] ALL_ONES = '1;

   assert_ref_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ref_cnt == $past(ref_cnt));
   assert_ref_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ref_cnt != ALL_ONES) |=> ref_cnt == $past(ref_cnt) + 1'b1);
   assert_ref_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ref_cnt == ALL_ONES) |=> ref_cnt == '0);
   assert_age_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> age_cnt == '0);
   assert_age_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age_cnt == ALL_ONES && !rise) |=> age_cnt == ALL_ONES);
   assert_stamp_math_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_vld |-> stamp == W'($past(ref_cnt) - $past(age_cnt)));
   assert_stamp_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_vld |-> ($past(snap) && $past(lvl)));
   assert_echo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !echo_en |-> !echo_out);
   assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> lvl);
endmodule

bind edge_stamp_timer edge_stamp_timer_chk #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .rise(rise), .lvl(lvl),
   .snap(snap), .ref_cnt(ref_cnt), .age_cnt(age_cnt), .stamp(stamp),
   .stamp_vld(stamp_vld), .echo_en(echo_en), .echo_out(echo_out));

// File: tb/sim_edge_stamp_timer.sv
module sim_stamp_model #(
   parameter int W = 16,
   parameter int P = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   input  logic         snap,
   output logic         lvl,
   output logic         s_lvl,
   output logic [W-1:0] s_ref,
   output logic [W-1:0] s_age,
   output logic         push,
   output logic [W-1:0] pval
);
   logic         s1, run, last;
   logic [W-1:0] rf, ag;
   int           pc;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 0; lvl <= 0; run <= 0; last <= 0; rf <= '0; ag <= '0; pc <= 0;
         s_lvl <= 0; s_ref <= '0; s_age <= '0; push <= 0; pval <= '0;
      end else begin
         if (pc == P - 1) begin pc <= 0; rf <= rf + 1'b1; end
         else pc <= pc + 1;
         if (s1 && !lvl) begin ag <= '0; run <= 1; end
         else if (pc == P - 1 && run && ag != {W{1'b1}}) ag <= ag + 1'b1;
         s1 <= evt; lvl <= s1;
         push <= snap && lvl && !last;
         if (snap) begin
            s_lvl <= lvl; s_ref <= rf; s_age <= ag; last <= lvl; pval <= rf - ag;
         end
      end
   end
endmodule

module sim_edge_stamp_timer;
   logic clk = 0, rst_n = 0;
   logic evt0 = 0, evt1 = 0, snap0 = 0, snap1 = 0;
   logic echo_en = 0, echo_inv = 0;
   logic [1:0]  rd_sel = 0;
   logic [15:0] rd0, st0, m0_sref, m0_sage, m0_pval;
   logic [7:0]  rd1, st1, m1_sref, m1_sage, m1_pval;
   logic v0, v1, eo0, eo1, m0_lvl, m1_lvl, m0_slvl, m1_slvl, m0_push, m1_push;
   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [15:0] q0[$];
   logic [7:0]  q1[$];

   always #4 clk = ~clk;

   edge_stamp_timer u0 (.clk(clk), .rst_n(rst_n), .evt_in(evt0), .snap(snap0),
      .rd_sel(rd_sel), .rd_data(rd0), .stamp(st0), .stamp_vld(v0),
      .echo_en(echo_en), .echo_inv(echo_inv), .echo_out(eo0));
   edge_stamp_timer #(.CNT_W(8)) u1 (.clk(clk), .rst_n(rst_n), .evt_in(evt1),
      .snap(snap1), .rd_sel(rd_sel), .rd_data(rd1), .stamp(st1), .stamp_vld(v1),
      .echo_en(echo_en), .echo_inv(echo_inv), .echo_out(eo1));

   sim_stamp_model #(.W(16), .P(4)) m0 (.clk(clk), .rst_n(rst_n), .evt(evt0),
      .snap(snap0), .lvl(m0_lvl), .s_lvl(m0_slvl), .s_ref(m0_sref),
      .s_age(m0_sage), .push(m0_push), .pval(m0_pval));
   sim_stamp_model #(.W(8), .P(4)) m1 (.clk(clk), .rst_n(rst_n), .evt(evt1),
      .snap(snap1), .lvl(m1_lvl), .s_lvl(m1_slvl), .s_ref(m1_sref),
      .s_age(m1_sage), .push(m1_push), .pval(m1_pval));

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // scoreboard monitor: expected stamps pushed, produced stamps popped
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (m0_push) q0.push_back(m0_pval);
         if (v0) begin
            if (q0.size() == 0) chk("R7 unexpected stamp u0", 1, 0);
            else chk("R6 stamp u0", st0, q0.pop_front());
         end else if (q0.size() != 0) begin
            chk("R6 missing stamp u0", 0, 1); q0.delete();
         end
         if (m1_push) q1.push_back(m1_pval);
         if (v1) begin
            if (q1.size() == 0) chk("R7 unexpected stamp u1", 1, 0);
            else chk("R6 stamp u1", st1, q1.pop_front());
         end else if (q1.size() != 0) begin
            chk("R6 missing stamp u1", 0, 1); q1.delete();
         end
      end
   end

   task automatic snap_u0();
      snap0 = 1; @(negedge clk); snap0 = 0;
   endtask
   task automatic snap_u1();
      snap1 = 1; @(negedge clk); snap1 = 0;
   endtask
   task automatic reads_u0(string tag);
      rd_sel = 0; #1 chk({tag, " R5 level u0"}, rd0, m0_slvl);
      rd_sel = 1; #1 chk({tag, " R5 ref u0"}, rd0, m0_sref);
      rd_sel = 2; #1 chk({tag, " R5 age u0"}, rd0, m0_sage);
      rd_sel = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      logic [15:0] a, b, held;
      logic [7:0]  p1, c1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R6 reset stamp_vld", v0, 0);
      chk("R6 reset stamp", st0, 0);
      chk("R8 reset echo", eo0, 0);
      snap_u0(); reads_u0("reset");
      rd_sel = 1; #1 chk("R1 reset ref near zero", rd0, 0);
      rd_sel = 0;
      @(negedge clk);
      repeat (6) @(negedge clk);
      snap_u0(); reads_u0("idle");
      rd_sel = 2; #1 chk("R3 age held before edge", rd0, 0);
      rd_sel = 1; #1 a = rd0; rd_sel = 0;
      @(negedge clk);
      repeat (2) @(negedge clk);
      snap_u0(); rd_sel = 1; #1 b = rd0; rd_sel = 0;
      chk("R1 one tick per four clocks", b - a, 1);
      @(negedge clk);
      repeat (6) @(negedge clk);
      snap_u0(); rd_sel = 1; #1 a = rd0; rd_sel = 0;
      chk("R1 two ticks per eight clocks", a - b, 2);
      // event rise, echo and synchronizer delay, phase varied per pass
      echo_en = 1; echo_inv = 0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         repeat (k) @(negedge clk);
         evt0 = 1;
         @(negedge clk); chk("R9 level not yet visible", eo0, 0);
         @(negedge clk); chk("R9 level after two clocks", eo0, 1);
         chk("R8 echo follows assert", eo0, m0_lvl);
         snap_u0(); reads_u0("edge");
         rd_sel = 2; #1 chk("R3 age cleared at edge", rd0, 0);
         rd_sel = 1; #1 chk("R6 stamp equals ref at edge", st0, rd0);
         rd_sel = 0;
         held = st0;
         @(negedge clk);
         snap_u0();
         chk("R7 no stamp on repeated high", v0, 0);
         chk("R7 stamp held", st0, held);
         repeat (37 + k) @(negedge clk);
         snap_u0(); reads_u0("aged");
         chk("R7 no stamp long after", v0, 0);
         evt0 = 0;
         repeat (2) @(negedge clk);
         chk("R8 echo follows deassert", eo0, 0);
         snap_u0(); reads_u0("low");
         chk("R7 no stamp when low", v0, 0);
         chk("R7 stamp held when low", st0, held);
      end
      // late poll: stamp recovers the edge time
      evt0 = 1;
      repeat (23) @(negedge clk);
      snap_u0(); reads_u0("late");
      rd_sel = 1; #1 a = rd0; rd_sel = 2; #1 b = rd0; rd_sel = 0;
      chk("R6 late stamp = ref - age", st0, a - b);
      chk("R3 age counted after edge", (b >= 5) ? 1 : 0, 1);
      // echo polarity and enable
      @(negedge clk);
      echo_inv = 1; #1 chk("R8 inverted echo high level", eo0, 0);
      evt0 = 0; repeat (2) @(negedge clk);
      chk("R8 inverted echo low level", eo0, 1);
      echo_en = 0; #1 chk("R8 echo disabled", eo0, 0);
      evt0 = 1; repeat (3) @(negedge clk);
      chk("R8 echo stays off", eo0, 0);
      rd_sel = 3; #1 chk("R5 select three reads zero", rd0, 0);
      rd_sel = 0;
      // narrow instance: reference wrap
      @(negedge clk);
      for (int i = 0; i < 300; i++) begin
         snap_u1();
         rd_sel = 1; #1 c1 = rd1; rd_sel = 0;
         chk("R5 ref u1 vs model", c1, m1_sref);
         if (i > 0) chk("R2 ref step across wrap", 8'(c1 - p1), 1);
         p1 = c1;
         @(negedge clk); @(negedge clk); @(negedge clk);
      end
      // narrow instance: age saturation
      evt1 = 1;
      repeat (4) @(negedge clk);
      snap_u1();
      repeat (256 * 4 + 40) @(negedge clk);
      snap_u1();
      rd_sel = 2; #1 chk("R4 age saturates", rd1, 8'hFF);
      rd_sel = 0;
      @(negedge clk);
      repeat (64) @(negedge clk);
      snap_u1();
      rd_sel = 2; #1 chk("R4 age stays saturated", rd1, 8'hFF);
      rd_sel = 0;
      evt1 = 0; repeat (3) @(negedge clk);
      snap_u1();
      evt1 = 1; repeat (2) @(negedge clk);
      snap_u1();
      rd_sel = 2; #1 chk("R3 new edge clears saturated age", rd1, 0);
      rd_sel = 0;
      repeat (5) @(negedge clk);
      chk("R6 scoreboard drained", q0.size() + q1.size(), 0);
      report();
   end
endmodule